// File: doc/BRIEF.md
# Receive-Ready Flag and Interrupt Bank

This block keeps one "new message received" flag for each of sixteen message objects, together with a matching bank of sixteen receive-interrupt mask bits. When the message store writes a received frame into an object's storage, it pulses a store strobe carrying the 4-bit object index. That pulse sets the object's flag. Software reads the flags through a byte-wide register port. It acknowledges a flag by writing a zero to its bit. Writing a one to a flag bit leaves that bit as it is.

Every hardware set of a flag is checked against the object's mask bit and against a global receive-interrupt enable. If both are on, the block emits a single-cycle interrupt request pulse, which goes to the surrounding interrupt controller. The flag and mask banks sit at four consecutive byte addresses. Reads return the stored contents combinationally.

Top module: `rx_ready_bank`

## Requirements
- R1: After reset, the flag bytes (0x04, 0x05) and the mask bytes (0x06, 0x07) all read 0x00, and `rx_irq` is 0.
- R2: Objects 0 to 7 are held in the byte at 0x04 and objects 8 to 15 in the byte at 0x05. Bit n of each byte belongs to object (lowest object of that byte + n).
- R3: A store strobe (`store_vld`=1 with index `store_idx`) sets that object's flag from the next clock edge on, and leaves every other flag unchanged.
- R4: A register write to a flag byte clears each flag whose data bit is 0. Flags whose data bit is 1 keep their value, so writing 0xFF changes nothing.
- R5: If a store strobe and a clearing write target the same flag in the same cycle, the flag ends up set. The other bits of that write are still applied.
- R6: The mask bytes at 0x06 (objects 0 to 7) and 0x07 (objects 8 to 15) use the R2 bit layout. They are plain read/write storage, and writing them does not change any flag.
- R7: A store strobe for an object whose mask bit is 1, while `rx_int_en`=1, makes `rx_irq` high for exactly one cycle, the cycle after the strobe. A strobe for an object whose mask bit is 0 gives no pulse.
- R8: While `rx_int_en`=0, store strobes give no `rx_irq` pulse, whatever the mask bits hold.
- R9: Reads of any address outside 0x04 to 0x07 return 0x00. Writes to such addresses change no flag and no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| store_vld | input | 1 | Pulse: a message was stored into an object |
| store_idx | input | 4 | Object index of the stored message |
| rx_int_en | input | 1 | Global receive-interrupt enable |
| rx_irq | output | 1 | One-cycle receive interrupt request pulse |

## Verification
The hardest situation to bring about is a hardware set and a software clear landing on the same flag in the same clock cycle. The ports only reach it if the store strobe and a zero write to the flag's byte are driven together. The bench first sets a neighbouring flag in that byte. It then drives the strobe and a 0x00 write to that byte in one cycle, and reads the byte back. This shows that the write cleared the neighbour while the struck object's flag survived. The interrupt cases toggle the mask bits and the global enable between strobes, and sample `rx_irq` in the cycle after each strobe and in the cycle after that.

// File: rtl/rrb_pkg.sv
package rrb_pkg;

    // Which register bank an address falls into
    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_FLAG = 2'd1,
        RK_MASK = 2'd2
    } reg_kind_e;

endpackage

// File: rtl/rrb_addr_decode.sv
module rrb_addr_decode
    import rrb_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                NUM_BYTES = 2,
    parameter int                BSEL_W    = 1,
    parameter logic [ADDR_W-1:0] FLAG_BASE = 8'h04,
    parameter logic [ADDR_W-1:0] MASK_BASE = 8'h06
) (
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    output reg_kind_e            rd_kind,
    output logic [BSEL_W-1:0]    rd_byte,
    output logic [NUM_BYTES-1:0] flag_we,
    output logic [NUM_BYTES-1:0] mask_we
);

    localparam logic [ADDR_W-1:0] SPAN      = ADDR_W'(NUM_BYTES);
    localparam logic [ADDR_W-1:0] FLAG_LAST = FLAG_BASE + SPAN;
    localparam logic [ADDR_W-1:0] MASK_LAST = MASK_BASE + SPAN;

    logic [ADDR_W-1:0] offs;

    always_comb begin
        rd_kind = RK_NONE;
        offs    = '0;
        if (reg_addr >= FLAG_BASE && reg_addr < FLAG_LAST) begin
            rd_kind = RK_FLAG;
            offs    = reg_addr - FLAG_BASE;
        end else if (reg_addr >= MASK_BASE && reg_addr < MASK_LAST) begin
            rd_kind = RK_MASK;
            offs    = reg_addr - MASK_BASE;
        end
        rd_byte = offs[BSEL_W-1:0];
    end

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_we
        assign flag_we[b] = reg_wr && (rd_kind == RK_FLAG) && (offs == ADDR_W'(b));
        assign mask_we[b] = reg_wr && (rd_kind == RK_MASK) && (offs == ADDR_W'(b));
    end

    // R9: an address outside both banks must never produce a write enable
    always_comb begin
        if (rd_kind == RK_NONE) begin
            a_no_stray_we_r9 : assert (flag_we == '0 && mask_we == '0)
                else $error("stray write enable for unmapped address");
        end
    end

endmodule

// File: rtl/rrb_flag_bank.sv
module rrb_flag_bank #(
    parameter int NUM_OBJ   = 16,
    parameter int DATA_W    = 8,
    parameter int NUM_BYTES = 2,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 store_vld,
    input  logic [IDX_W-1:0]     store_idx,
    input  logic [NUM_BYTES-1:0] byte_we,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_OBJ-1:0]   flags
);

    typedef struct packed {
        logic [NUM_OBJ-1:0] flags;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // software acknowledge: a zero data bit clears, a one keeps
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (byte_we[b]) begin
                for (int k = 0; k < DATA_W; k++) begin
                    if (!wdata[k]) st_d.flags[b*DATA_W + k] = 1'b0;
                end
            end
        end
        // hardware set comes last so it wins over a clear in the same cycle
        if (store_vld) st_d.flags[store_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

    // R3 / R5: a strobed object is always set afterwards
    p_set_lands_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        store_vld |=> flags[$past(store_idx)])
        else $error("strobed flag not set");

    // R4: a flag only falls when software wrote a flag byte
    p_clear_needs_write_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        ((~flags & $past(flags)) != '0) |-> $past(byte_we != '0))
        else $error("flag dropped without a software write");

    // R4: writing all ones to every selected byte cannot drop a flag
    p_ones_keep_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (wdata == '1) |=> ((~flags & $past(flags)) == '0))
        else $error("all-ones write cleared a flag");

endmodule

// File: rtl/rrb_mask_bank.sv
module rrb_mask_bank #(
    parameter int NUM_OBJ   = 16,
    parameter int DATA_W    = 8,
    parameter int NUM_BYTES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BYTES-1:0] byte_we,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_OBJ-1:0]   mask
);

    typedef struct packed {
        logic [NUM_OBJ-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (byte_we[b]) st_d.mask[b*DATA_W +: DATA_W] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask = st_q.mask;

    // R6: mask bits only move on a mask write
    p_mask_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we == '0) |=> $stable(mask))
        else $error("mask changed without a write");

endmodule

// File: rtl/rrb_irq_gen.sv
module rrb_irq_gen #(
    parameter int NUM_OBJ = 16,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               store_vld,
    input  logic [IDX_W-1:0]   store_idx,
    input  logic [NUM_OBJ-1:0] mask,
    input  logic               rx_int_en,
    output logic               rx_irq
);

    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = store_vld && rx_int_en && mask[store_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_irq = st_q.irq;

    // R8: no request unless the global enable was on at the strobe
    p_irq_needs_enable_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> ($past(rx_int_en) && $past(store_vld)))
        else $error("interrupt without enable or strobe");

    // R7: an unmasked, enabled strobe requests an interrupt next cycle
    p_irq_fires_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (store_vld && rx_int_en && mask[store_idx]) |=> rx_irq)
        else $error("enabled strobe gave no interrupt");

    // R7: a masked strobe gives no request
    p_irq_masked_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (store_vld && !mask[store_idx]) |=> !rx_irq)
        else $error("masked strobe gave an interrupt");

endmodule

// File: rtl/rx_ready_bank.sv
module rx_ready_bank
    import rrb_pkg::*;
#(
    parameter int                NUM_OBJ   = 16,
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_BASE = 8'h04,
    parameter logic [ADDR_W-1:0] MASK_BASE = 8'h06
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    input  logic                       store_vld,
    input  logic [$clog2(NUM_OBJ)-1:0] store_idx,
    input  logic                       rx_int_en,
    output logic                       rx_irq
);

    localparam int IDX_W     = $clog2(NUM_OBJ);
    localparam int NUM_BYTES = NUM_OBJ / DATA_W;
    localparam int BSEL_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

    reg_kind_e              rd_kind;
    logic [BSEL_W-1:0]      rd_byte;
    logic [NUM_BYTES-1:0]   flag_we;
    logic [NUM_BYTES-1:0]   mask_we;
    logic [NUM_OBJ-1:0]     flags;
    logic [NUM_OBJ-1:0]     mask;

    rrb_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BYTES (NUM_BYTES),
        .BSEL_W    (BSEL_W),
        .FLAG_BASE (FLAG_BASE),
        .MASK_BASE (MASK_BASE)
    ) u_decode (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .rd_kind  (rd_kind),
        .rd_byte  (rd_byte),
        .flag_we  (flag_we),
        .mask_we  (mask_we)
    );

    rrb_flag_bank #(
        .NUM_OBJ   (NUM_OBJ),
        .DATA_W    (DATA_W),
        .NUM_BYTES (NUM_BYTES),
        .IDX_W     (IDX_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_vld (store_vld),
        .store_idx (store_idx),
        .byte_we   (flag_we),
        .wdata     (reg_wdata),
        .flags     (flags)
    );

    rrb_mask_bank #(
        .NUM_OBJ   (NUM_OBJ),
        .DATA_W    (DATA_W),
        .NUM_BYTES (NUM_BYTES)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_we (mask_we),
        .wdata   (reg_wdata),
        .mask    (mask)
    );

    rrb_irq_gen #(
        .NUM_OBJ (NUM_OBJ),
        .IDX_W   (IDX_W)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_vld (store_vld),
        .store_idx (store_idx),
        .mask      (mask),
        .rx_int_en (rx_int_en),
        .rx_irq    (rx_irq)
    );

    // combinational read path
    always_comb begin
        case (rd_kind)
            RK_FLAG: reg_rdata = flags[rd_byte*DATA_W +: DATA_W];
            RK_MASK: reg_rdata = mask[rd_byte*DATA_W +: DATA_W];
            default: reg_rdata = '0;
        endcase
    end

    // R9: unmapped reads return zero
    p_unmapped_zero_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (rd_kind == RK_NONE) |-> (reg_rdata == '0))
        else $error("unmapped read returned data");

    // R1: the request output is low in the first cycle out of reset
    p_irq_low_after_reset_r1 : assert property (@(posedge clk)
        $rose(rst_n) |-> !rx_irq)
        else $error("interrupt high out of reset");

endmodule

// File: tb/rx_ready_bank_bench.sv
module rx_ready_bank_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       store_vld = 1'b0;
    logic [3:0] store_idx = 4'd0;
    logic       rx_int_en = 1'b0;
    logic       rx_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rx_ready_bank u_rx_ready_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .store_vld (store_vld),
        .store_idx (store_idx),
        .rx_int_en (rx_int_en),
        .rx_irq    (rx_irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // one clock: inputs applied after a negedge, results visible at the next negedge
    task automatic cycle(input logic wr, input logic [7:0] a, input logic [7:0] d,
                         input logic sv, input logic [3:0] idx);
        reg_wr    = wr;
        reg_addr  = a;
        reg_wdata = d;
        store_vld = sv;
        store_idx = idx;
        @(negedge clk);
        reg_wr    = 1'b0;
        store_vld = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        cycle(1'b1, a, d, 1'b0, 4'd0);
    endtask

    task automatic strobe(input logic [3:0] idx);
        cycle(1'b0, 8'h00, 8'h00, 1'b1, idx);
    endtask

    task automatic expect_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        expect_reg("R1 flag lo", 8'h04, 8'h00);
        expect_reg("R1 flag hi", 8'h05, 8'h00);
        expect_reg("R1 mask lo", 8'h06, 8'h00);
        expect_reg("R1 mask hi", 8'h07, 8'h00);
        check("R1 irq", {7'd0, rx_irq}, 8'h00);
    endtask

    task automatic t_map;
        strobe(4'd3);
        expect_reg("R3 obj3 low byte", 8'h04, 8'h08);
        expect_reg("R2 high byte untouched", 8'h05, 8'h00);
        strobe(4'd12);
        expect_reg("R2 obj12 high byte", 8'h05, 8'h10);
        expect_reg("R3 low byte kept", 8'h04, 8'h08);
        strobe(4'd15);
        strobe(4'd0);
        expect_reg("R2 obj15", 8'h05, 8'h90);
        expect_reg("R2 obj0", 8'h04, 8'h09);
    endtask

    task automatic t_clear;
        strobe(4'd6);
        wr_reg(8'h04, 8'hFF);
        expect_reg("R4 ones keep low", 8'h04, 8'h49);
        wr_reg(8'h05, 8'hFF);
        expect_reg("R4 ones keep high", 8'h05, 8'h90);
        wr_reg(8'h04, 8'hF7);
        expect_reg("R4 selective clear", 8'h04, 8'h41);
        expect_reg("R4 other byte kept", 8'h05, 8'h90);
        wr_reg(8'h04, 8'h00);
        wr_reg(8'h05, 8'h00);
        expect_reg("R4 full clear lo", 8'h04, 8'h00);
        expect_reg("R4 full clear hi", 8'h05, 8'h00);
    endtask

    task automatic t_set_wins;
        strobe(4'd8);
        cycle(1'b1, 8'h05, 8'h00, 1'b1, 4'd9);
        expect_reg("R5 set beats clear", 8'h05, 8'h02);
        wr_reg(8'h05, 8'h00);
    endtask

    task automatic t_mask;
        strobe(4'd2);
        wr_reg(8'h06, 8'hA5);
        wr_reg(8'h07, 8'h3C);
        expect_reg("R6 mask lo", 8'h06, 8'hA5);
        expect_reg("R6 mask hi", 8'h07, 8'h3C);
        expect_reg("R6 flags untouched", 8'h04, 8'h04);
        wr_reg(8'h04, 8'h00);
    endtask

    task automatic t_irq;
        rx_int_en = 1'b1;
        strobe(4'd0);   // mask bit 0 = 1
        check("R7 pulse", {7'd0, rx_irq}, 8'h01);
        @(negedge clk);
        check("R7 single cycle", {7'd0, rx_irq}, 8'h00);
        strobe(4'd1);   // mask bit 1 = 0
        check("R7 masked", {7'd0, rx_irq}, 8'h00);
        strobe(4'd10);  // mask hi bit 2 = 1
        check("R7 high object", {7'd0, rx_irq}, 8'h01);
        strobe(4'd10);  // back-to-back strobes pulse again
        check("R7 repeat event", {7'd0, rx_irq}, 8'h01);
        @(negedge clk);
        check("R7 falls", {7'd0, rx_irq}, 8'h00);
    endtask

    task automatic t_global;
        rx_int_en = 1'b0;
        wr_reg(8'h06, 8'hFF);
        wr_reg(8'h07, 8'hFF);
        strobe(4'd0);
        check("R8 disabled obj0", {7'd0, rx_irq}, 8'h00);
        strobe(4'd13);
        check("R8 disabled obj13", {7'd0, rx_irq}, 8'h00);
        rx_int_en = 1'b1;
    endtask

    task automatic t_unmapped;
        logic [7:0] lo, hi;
        rd(8'h04, lo);
        rd(8'h05, hi);
        wr_reg(8'h08, 8'h00);
        wr_reg(8'h03, 8'h00);
        wr_reg(8'h00, 8'h00);
        expect_reg("R9 flags lo kept", 8'h04, lo);
        expect_reg("R9 flags hi kept", 8'h05, hi);
        expect_reg("R9 mask lo kept", 8'h06, 8'hFF);
        expect_reg("R9 read 0x03", 8'h03, 8'h00);
        expect_reg("R9 read 0x08", 8'h08, 8'h00);
        expect_reg("R9 read 0xFF", 8'hFF, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_clear();
        t_set_wins();
        t_mask();
        t_irq();
        t_global();
        t_unmapped();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule